// File: doc/BRIEF.md
# Programmable Status LED Driver

This block turns a set of seven status inputs into one indicator output. A configuration word chooses which inputs count. The indicator lights whenever the OR of the chosen inputs is true, and several inputs may be chosen at once. An optional hold timer keeps short events visible: each new rising edge of the combined value keeps the indicator lit for a fixed number of clocks.

Software reaches the block through a 32-bit write/read word. The low byte holds the source enables and the hold-timer switch. Bit 15 is read-only and shows the raw, unheld combined value live, while the link-pass input is high. A hard reset (`rst`) loads the default configuration: the link source only, with the hold timer on. A soft reset (`soft_rst`) keeps the configuration and only cancels a hold that is running. The indicator output is active-low.

Top module: `status_lamp`

## Requirements
- R1: After hard reset the read word is 0x000000C0, with all status inputs low: enable bit 6 and hold switch bit 7 are set. The indicator output `lamp_n` is 1 (dark) in the first cycle after reset.
- R2: Enable bit i (bits 6..0) admits `evt_src[i]`. The combined value is the OR over i of `evt_src[i] & enable[i]`, and a status input with its enable clear has no effect on `lamp_n` or on bit 15.
- R3: With bit 7 clear, `lamp_n` is the inverse of the combined value sampled at the previous clock edge (one register stage). It is 0 when lit.
- R4: With bit 7 set, a rising edge of the combined value lights the indicator for HOLD_CLKS cycles, starting at the clock edge that samples the edge. The indicator also stays lit for as long as the combined value is high.
- R5: A new rising edge while a hold is running restarts the full HOLD_CLKS count.
- R6: Read bit 15 equals the live combined value while `link_ok` is 1 and reads 0 while `link_ok` is 0. Writes to bit 15 are ignored.
- R7: Read bits 31..16 and 14..8 are always 0, and writes to them are ignored.
- R8: `soft_rst` leaves bits 7..0 unchanged and cancels a running hold. At the next edge `lamp_n` becomes the inverse of the combined value.
- R9: A write takes effect in the read word one cycle after the edge that samples it. A hard reset in the same cycle as a write wins, and the read word shows 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hard reset, synchronous, active-high |
| soft_rst | input | 1 | Soft reset strobe; keeps configuration |
| link_ok | input | 1 | Link in pass state; qualifies read bit 15 |
| evt_src | input | 7 | Status event inputs |
| reg_wr_en | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Read word: enables, hold switch, live bit |
| lamp_n | output | 1 | Indicator drive, active-low |

## Verification
A corrupted enable or hold-switch flop shows at once in the read word. It also shows in `lamp_n` one edge after any event on an affected input. A hold counter that loads the wrong value, or does not restart, changes the length of the dark-to-lit-to-dark window, and the bench measures that length to the exact cycle. The live bit is compared combinationally in every cycle, so a wrong gating term shows in the same cycle it occurs.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
    localparam int NSRC      = 7;
    localparam int WORD_W    = 32;
    localparam int LIVE_POS  = 15;
    localparam int HOLD_POS  = NSRC;

    typedef struct packed {
        logic            hold_on;
        logic [NSRC-1:0] src_en;
    } lamp_cfg_t;

    localparam lamp_cfg_t CFG_HARD_DEFAULT = '{hold_on: 1'b1, src_en: 7'h40};

    function automatic lamp_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        lamp_cfg_t c;
        c.hold_on = w[HOLD_POS];
        c.src_en  = w[NSRC-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input lamp_cfg_t c, input logic live);
        logic [WORD_W-1:0] w;
        w                 = '0;
        w[NSRC-1:0]       = c.src_en;
        w[HOLD_POS]       = c.hold_on;
        w[LIVE_POS]       = live;
        return w;
    endfunction
endpackage

// File: rtl/lamp_cfg_reg.sv
module lamp_cfg_reg
    import lamp_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output lamp_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (hard_rst) begin
            cfg <= CFG_HARD_DEFAULT;
        end else if (wr_en) begin
            cfg <= cfg_from_word(wdata);
        end
    end
endmodule

// File: rtl/lamp_combine.sv
module lamp_combine
    import lamp_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    input  logic         link_ok,
    output logic         any,
    output logic         live
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = src[i] & en[i];
    end

    assign any  = |gated;
    assign live = any & link_ok;
endmodule

// File: rtl/lamp_stretch.sv
module lamp_stretch #(
    parameter int HOLD_CLKS = 10_000_000
) (
    input  logic clk,
    input  logic hard_rst,
    input  logic soft_rst,
    input  logic hold_on,
    input  logic any,
    output logic lamp_on
);
    localparam int          CW   = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CLKS - 1);

    logic          any_q;
    logic [CW-1:0] left;
    logic          rise;
    logic          holding;

    assign rise    = any & ~any_q;
    assign holding = (left != '0);

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            any_q   <= 1'b0;
            left    <= '0;
            lamp_on <= 1'b0;
        end else if (soft_rst) begin
            any_q   <= any;
            left    <= '0;
            lamp_on <= any;
        end else begin
            any_q   <= any;
            lamp_on <= hold_on ? (any | holding) : any;
            if (rise) begin
                left <= LOAD;
            end else if (holding) begin
                left <= left - CW'(1);
            end
        end
    end
endmodule

// File: rtl/status_lamp.sv
module status_lamp
    import lamp_pkg::*;
#(
    parameter int HOLD_CLKS = 10_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              link_ok,
    input  logic [NSRC-1:0]   evt_src,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              lamp_n
);
    lamp_cfg_t cfg;
    logic      any;
    logic      live;
    logic      lamp_on;

    lamp_cfg_reg u_cfg (
        .clk      (clk),
        .hard_rst (rst),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .cfg      (cfg)
    );

    lamp_combine #(.N(NSRC)) u_comb (
        .src     (evt_src),
        .en      (cfg.src_en),
        .link_ok (link_ok),
        .any     (any),
        .live    (live)
    );

    lamp_stretch #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
        .clk      (clk),
        .hard_rst (rst),
        .soft_rst (soft_rst),
        .hold_on  (cfg.hold_on),
        .any      (any),
        .lamp_on  (lamp_on)
    );

    assign reg_rdata = word_from_cfg(cfg, live);
    assign lamp_n    = ~lamp_on;
endmodule

// File: rtl/status_lamp_chk.sv
module status_lamp_chk
    import lamp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              link_ok,
    input logic [NSRC-1:0]   evt_src,
    input logic              reg_wr_en,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              lamp_n
);
    logic comb_now;
    assign comb_now = |(evt_src & reg_rdata[NSRC-1:0]);

    // R1
    hard_default_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_rdata[7:0] == 8'hC0 && lamp_n));

    // R3
    plain_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[HOLD_POS] && !soft_rst) |=> (lamp_n == !$past(comb_now)));

    // R4
    hold_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[HOLD_POS] && comb_now) |=> !lamp_n);

    // R6
    live_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !link_ok |-> !reg_rdata[LIVE_POS]);

    // R2
    live_match_chk: assert property (@(posedge clk) disable iff (rst)
        link_ok |-> (reg_rdata[LIVE_POS] == comb_now));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:16] == 16'h0) && (reg_rdata[14:8] == 7'h0));

    // R8
    soft_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !reg_wr_en) |=> $stable(reg_rdata[7:0]));

    // R8
    soft_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (lamp_n == !$past(comb_now)));

    // R9
    write_take_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> (reg_rdata[7:0] == $past(reg_wdata[7:0])));
endmodule

bind status_lamp status_lamp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .link_ok   (link_ok),
    .evt_src   (evt_src),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lamp_n    (lamp_n)
);

// File: tb/status_lamp_bench.sv
`timescale 1ns/1ps
module status_lamp_bench;
    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        link_ok = 1'b1;
    logic [6:0]  evt_src = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lamp_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    status_lamp #(.HOLD_CLKS(HOLD)) u_status_lamp (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .link_ok(link_ok),
        .evt_src(evt_src), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lamp_n(lamp_n)
    );

    // behavioural reference model
    bit [6:0] m_en   = 7'h40;
    bit       m_hold = 1'b1;
    bit       m_lit  = 1'b0;
    bit       m_prev = 1'b0;
    int       m_left = 0;

    function automatic bit m_comb();
        return (evt_src & m_en) != 0;
    endfunction

    always @(posedge clk) begin
        bit c;
        c = m_comb();
        if (rst) begin
            m_en = 7'h40; m_hold = 1'b1; m_lit = 1'b0; m_prev = 1'b0; m_left = 0;
        end else begin
            if (soft_rst) begin
                m_lit = c; m_left = 0;
            end else begin
                m_lit = m_hold ? (c || m_left > 0) : c;
                if (c && !m_prev) m_left = HOLD - 1;
                else if (m_left > 0) m_left--;
            end
            m_prev = c;
            if (reg_wr_en) begin
                m_en = reg_wdata[6:0]; m_hold = reg_wdata[7];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] exp_w;
            exp_w = {16'h0, link_ok & m_comb(), 7'h0, m_hold, m_en};
            check(m_hold ? "R4 lamp_n vs model" : "R3 lamp_n vs model", {31'h0, lamp_n}, {31'h0, ~m_lit});
            check("R6/R7 read word vs model", reg_rdata, exp_w);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic write_cfg(input logic [31:0] v);
        reg_wr_en = 1'b1; reg_wdata = v;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [6:0] v);
        evt_src = v;
        tick();
        evt_src = '0;
    endtask

    task automatic count_lit(output int n);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (lamp_n == 1'b0) n++;
            else break;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
    end

    initial begin
        int n;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset word", reg_rdata, 32'h0000_00C0);
        check("R1 reset lamp_n dark", {31'h0, lamp_n}, 32'h1);

        // R7: reserved and bit 15 writes ignored
        tick();
        write_cfg(32'hFFFF_FF7F);
        @(negedge clk);
        check("R7 reserved write ignored", reg_rdata, 32'h0000_007F);

        // R3: hold off, one-cycle pulse follows with one stage
        pulse(7'h01);
        @(negedge clk);
        check("R3 lamp lit one stage after event", {31'h0, lamp_n}, 32'h0);
        tick();
        @(negedge clk);
        check("R3 lamp dark after event ends", {31'h0, lamp_n}, 32'h1);

        // R2: only enabled sources count
        write_cfg(32'h0000_0005);
        evt_src = 7'h02;
        tick();
        @(negedge clk);
        check("R2 disabled source keeps lamp dark", {31'h0, lamp_n}, 32'h1);
        check("R2 disabled source leaves bit15 low", {31'h0, reg_rdata[15]}, 32'h0);
        evt_src = 7'h04;
        #1;
        check("R6 bit15 live with link", {31'h0, reg_rdata[15]}, 32'h1);
        link_ok = 1'b0;
        #1;
        check("R6 bit15 zero without link", {31'h0, reg_rdata[15]}, 32'h0);
        link_ok = 1'b1;
        tick();
        @(negedge clk);
        check("R2 enabled source lights lamp", {31'h0, lamp_n}, 32'h0);
        evt_src = '0;
        tick();

        // R4: hold length
        write_cfg(32'h0000_0081);
        repeat (2) tick();
        pulse(7'h01);
        count_lit(n);
        check("R4 hold length", n, HOLD + 0);

        // R5: restart during a hold
        tick();
        pulse(7'h01);
        repeat (3) tick();
        pulse(7'h01);
        count_lit(n);
        check("R5 restart gives full hold", n, HOLD + 0);

        // R8: soft reset cancels hold, keeps config
        tick();
        pulse(7'h01);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        @(negedge clk);
        check("R8 soft reset cancels hold", {31'h0, lamp_n}, 32'h1);
        check("R8 soft reset keeps config", reg_rdata, 32'h0000_0081);

        // R9: hard reset beats write; write visible next cycle
        rst = 1'b1; reg_wr_en = 1'b1; reg_wdata = 32'h0000_003F;
        tick();
        rst = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
        @(negedge clk);
        check("R9 reset wins over write", reg_rdata, 32'h0000_00C0);
        write_cfg(32'h0000_0013);
        @(negedge clk);
        check("R9 write visible next cycle", reg_rdata, 32'h0000_0013);

        repeat (4) tick();
        done = 1'b1;
        summary();
    end
endmodule